// File: doc/BRIEF.md
# Potentiometer Counter and Shared Pin Port

This block times how long four externally charged capacitors take to reach a logic threshold. The result is four 8-bit resistance readings. A write to the control register with bit 0 set starts a measurement. All four pins are first pulled low for a fixed number of horizontal-line strobes, which discharges the capacitors. The pins are then released. Each counter advances once per line strobe until its pin reads high. A faster line strobe therefore gives proportionally larger readings for the same resistor.

The four pins also form a small bidirectional port. Every pin has a drive-enable bit and a level bit in the upper byte of the control register. A read path returns the live pin levels at the same bit positions as the level bits. Pins are indexed 0 = left X, 1 = left Y, 2 = right X, 3 = right Y.

The threshold comparators are digital inputs. The line strobe comes from outside the block. No data stream passes through this block, so every interface is a plain control or status pin with no valid/ready handshake or back-pressure. A register write is a single-cycle strobe, and register reads are continuously valid outputs.

Top module: `pot_port`

## Requirements
- R1: After reset all four counters read 0, no pin is driven (`pin_oe` = 0), and no counter advances until a measurement is started.
- R2: `pot_left` carries pin 1 (left Y) in bits 15:8 and pin 0 (left X) in bits 7:0. `pot_right` carries pin 3 in bits 15:8 and pin 2 in bits 7:0.
- R3: A write with bit 0 set clears all counters on that edge. It then drives all four pins low (`pin_oe` = 4'hF, `pin_out` = 0) for exactly DUMP_LINES line strobes, with the counters held at 0.
- R4: Counting begins at the first line strobe after the discharge phase. Each later line strobe raises every running counter by exactly 1 while its pin input is low.
- R5: Once a counter's pin reads high during the counting phase, that counter stops. It stays stopped even if the pin falls again, until the next start.
- R6: A counter that reaches 0xFF stays at 0xFF and never wraps.
- R7: Outside the discharge phase, pin i is driven when control bit 9+2i is set, and `pin_out[i]` follows control bit 8+2i. A counter whose pin is driven does not advance.
- R8: `pin_rd` shows the live level of pin i at bit 8+2i (bits 8, 10, 12, 14). All other bits are 0.
- R9: A start during a measurement clears all counters at once and restarts the full discharge phase.
- R10: A write with bit 0 clear updates only the drive bits (bits 15:8). Counter values and the measurement phase are unchanged. Bits 7:1 are ignored.
- R11: Apart from the clear at a start, counter values change only at a clock edge where `line_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write data: drive pairs in 15:8, start in bit 0 |
| pin_in | input | 4 | Threshold / level input of each shared pin |
| pin_oe | output | 4 | Drive enable for each pin |
| pin_out | output | 4 | Drive level for each pin |
| pot_left | output | 16 | Left counter pair, Y in 15:8, X in 7:0 |
| pot_right | output | 16 | Right counter pair, Y in 15:8, X in 7:0 |
| pin_rd | output | 16 | Live pin levels at bits 14, 12, 10, 8 |

## Verification
The assertions check several rules on every cycle:
- During discharge, every pin is forced low and all counters read zero.
- Counters never decrease and never leave 0xFF, except at a start.
- No counter moves on a cycle without a line strobe.

The bench's scenarios are needed for the rest:
- the exact length of the discharge phase and the first counting strobe;
- a counter staying stopped after its pin drops again;
- a driven pin freezing its counter;
- the mid-measurement restart;
- the placement of fields in the read registers.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DUMP  = 2'd1,
    PH_COUNT = 2'd2
  } phase_e;
endpackage

// File: rtl/pot_seq.sv
module pot_seq
  import pot_pkg::*;
#(
  parameter int DUMP_LINES = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   line_stb,
  output phase_e phase
);
  localparam int DW = $clog2(DUMP_LINES) + 1;
  localparam logic [DW-1:0] LAST = DW'(DUMP_LINES - 1);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      dcnt  <= '0;
    end else if (start) begin
      phase <= PH_DUMP;
      dcnt  <= '0;
    end else if (phase == PH_DUMP && line_stb) begin
      if (dcnt == LAST) phase <= PH_COUNT;
      else              dcnt  <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pot_chan.sv
module pot_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          count_en,
  input  logic          line_stb,
  input  logic          hold,
  input  logic          level,
  output logic [CW-1:0] cnt
);
  logic stopped;
  logic adv;

  assign adv = count_en && line_stb && !stopped && !level && !hold && (cnt != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else begin
      if (adv)               cnt     <= cnt + 1'b1;
      if (count_en && level) stopped <= 1'b1;
    end
  end
endmodule

// File: rtl/pot_port.sv
module pot_port
  import pot_pkg::*;
#(
  parameter int CW         = 8,
  parameter int DUMP_LINES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_stb,
  input  logic            ctrl_we,
  input  logic [15:0]     ctrl_wdata,
  input  logic [3:0]      pin_in,
  output logic [3:0]      pin_oe,
  output logic [3:0]      pin_out,
  output logic [2*CW-1:0] pot_left,
  output logic [2*CW-1:0] pot_right,
  output logic [15:0]     pin_rd
);
  localparam int NPIN = 4;

  phase_e            phase;
  logic              start;
  logic              dumping;
  logic              counting;
  logic [7:0]        drv;
  logic [CW-1:0]     cnt [NPIN];
  logic              wr_unused_bits;

  assign start          = ctrl_we && ctrl_wdata[0];
  assign wr_unused_bits = ^ctrl_wdata[7:1];
  assign dumping        = (phase == PH_DUMP);
  assign counting       = (phase == PH_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drv <= '0;
    else if (ctrl_we) drv <= ctrl_wdata[15:8];
  end

  pot_seq #(.DUMP_LINES(DUMP_LINES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .line_stb (line_stb),
    .phase    (phase)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pot_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .count_en (counting),
      .line_stb (line_stb),
      .hold     (drv[2*i+1]),
      .level    (pin_in[i]),
      .cnt      (cnt[i])
    );
    assign pin_oe[i]      = dumping | drv[2*i+1];
    assign pin_out[i]     = !dumping & drv[2*i];
    assign pin_rd[8+2*i]  = pin_in[i];
    assign pin_rd[9+2*i]  = 1'b0;
  end

  assign pin_rd[7:0] = '0;
  assign pot_left    = {cnt[1], cnt[0]};
  assign pot_right   = {cnt[3], cnt[2]};
endmodule

// File: rtl/pot_port_chk.sv
module pot_port_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_stb,
  input logic            start,
  input logic            dumping,
  input logic [3:0]      pin_oe,
  input logic [3:0]      pin_out,
  input logic [2*CW-1:0] pot_left,
  input logic [2*CW-1:0] pot_right
);
  logic [4*CW-1:0] all_cnt;
  assign all_cnt = {pot_right, pot_left};

  // R3
  dump_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dumping |-> (pin_oe == 4'hF && pin_out == 4'h0));

  // R3
  dump_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dumping |-> all_cnt == '0);

  for (genvar i = 0; i < 4; i++) begin : g_c
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(all_cnt[i*CW +: CW]) == {CW{1'b1}} && !$past(start))
        |-> all_cnt[i*CW +: CW] == {CW{1'b1}});

    // R4
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> all_cnt[i*CW +: CW] >= $past(all_cnt[i*CW +: CW]));

    // R11
    strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(line_stb) && !$past(start)) |-> $stable(all_cnt[i*CW +: CW]));
  end
endmodule

bind pot_port pot_port_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_stb  (line_stb),
  .start     (ctrl_we & ctrl_wdata[0]),
  .dumping   (dumping),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pot_left  (pot_left),
  .pot_right (pot_right)
);

// File: tb/sim_pot_port.sv
`timescale 1ns/1ps
module sim_pot_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_stb = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_oe, pin_out;
  logic [15:0] pot_left, pot_right, pin_rd;

  int ntest = 0;
  int nfail = 0;
  int cyc   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pot_port u0 (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pot_left(pot_left), .pot_right(pot_right),
    .pin_rd(pin_rd)
  );

  // behavioural reference model
  int         m_ph;
  int         m_d;
  int         m_cnt [4];
  bit         m_stop[4];
  logic [7:0] m_drv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_d = 0; m_drv = '0;
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_stop[i] = 0; end
    end else begin
      if (ctrl_we && ctrl_wdata[0]) begin
        m_ph = 1; m_d = 0;
        for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_stop[i] = 0; end
      end else if (m_ph == 1) begin
        if (line_stb) begin
          if (m_d == 7) m_ph = 2;
          else m_d = m_d + 1;
        end
      end else if (m_ph == 2) begin
        for (int i = 0; i < 4; i++) begin
          if (line_stb && !m_stop[i] && !pin_in[i] && !m_drv[2*i+1] && m_cnt[i] < 255)
            m_cnt[i] = m_cnt[i] + 1;
          if (pin_in[i]) m_stop[i] = 1;
        end
      end
      if (ctrl_we) m_drv = ctrl_wdata[15:8];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0]  e_oe, e_out;
    logic [15:0] e_rd;
    e_rd = '0;
    for (int i = 0; i < 4; i++) begin
      e_oe[i]      = (m_ph == 1) || m_drv[2*i+1];
      e_out[i]     = (m_ph != 1) && m_drv[2*i];
      e_rd[8+2*i]  = pin_in[i];
    end
    if (rst_n && !done) begin
      chk("R2 left", {16'h0, pot_left},  {16'h0, m_cnt[1][7:0], m_cnt[0][7:0]});
      chk("R2 right", {16'h0, pot_right}, {16'h0, m_cnt[3][7:0], m_cnt[2][7:0]});
      chk("R7 oe",  {28'h0, pin_oe},  {28'h0, e_oe});
      chk("R7 out", {28'h0, pin_out}, {28'h0, e_out});
      chk("R8 rd",  {16'h0, pin_rd},  {16'h0, e_rd});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      ntest++; nfail++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  task automatic wr(logic [15:0] d);
    @(posedge clk); #1 ctrl_we = 1'b1; ctrl_wdata = d;
    @(posedge clk); #1 ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic strobes(int n);
    repeat (n) begin
      @(posedge clk); #1 line_stb = 1'b1;
      @(posedge clk); #1 line_stb = 1'b0;
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic setpin(logic [3:0] v);
    @(posedge clk); #1 pin_in = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 counters", {pot_right, pot_left}, 32'h0);
    chk("R1 drive", {28'h0, pin_oe}, 32'h0);
    strobes(3);
    @(negedge clk) chk("R1 idle", {pot_right, pot_left}, 32'h0);

    wr(16'h0001);
    @(negedge clk) chk("R3 dump oe", {28'h0, pin_oe}, 32'hF);
    chk("R3 dump out", {28'h0, pin_out}, 32'h0);
    strobes(7);
    @(negedge clk) chk("R3 still dumping", {28'h0, pin_oe}, 32'hF);
    strobes(1);
    @(negedge clk) chk("R3 released", {28'h0, pin_oe}, 32'h0);
    chk("R4 zero at release", {pot_right, pot_left}, 32'h0);
    strobes(5);
    @(negedge clk) chk("R4 count", {pot_right, pot_left}, 32'h0505_0505);
    setpin(4'b0001);
    strobes(3);
    @(negedge clk) chk("R5 stop", {16'h0, pot_left}, 32'h0805);
    setpin(4'b0000);
    strobes(2);
    @(negedge clk) chk("R5 stays stopped", {16'h0, pot_left}, 32'h0A05);
    strobes(300);
    @(negedge clk) chk("R6 saturate", {pot_right, pot_left}, 32'hFFFF_FF05);

    setpin(4'b1010);
    @(negedge clk) chk("R8 pin read", {16'h0, pin_rd}, 32'h4400);
    setpin(4'b0000);
    repeat (20) @(posedge clk);
    @(negedge clk) chk("R11 no strobe", {pot_right, pot_left}, 32'hFFFF_FF05);

    wr(16'h30FE);
    @(negedge clk) chk("R7 drive oe", {28'h0, pin_oe}, 32'h4);
    chk("R7 drive out", {28'h0, pin_out}, 32'h4);
    chk("R10 counters kept", {pot_right, pot_left}, 32'hFFFF_FF05);

    wr(16'h3001);
    strobes(8);
    strobes(6);
    @(negedge clk) chk("R7 held counter", {16'h0, pot_right}, 32'h0600);
    chk("R7 oe after dump", {28'h0, pin_oe}, 32'h4);

    wr(16'h0001);
    @(negedge clk) chk("R9 restart clears", {pot_right, pot_left}, 32'h0);
    chk("R9 dump again", {28'h0, pin_oe}, 32'hF);
    strobes(7);
    @(negedge clk) chk("R9 full dump", {28'h0, pin_oe}, 32'hF);
    strobes(1);
    strobes(2);
    @(negedge clk) chk("R9 recount", {pot_right, pot_left}, 32'h0202_0202);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule